// File: doc/BRIEF.md
# Override-Gated Configuration Output Selector

This block drives six open-drain configuration lines from a stored configuration word. Five lines are multiplexed. A select input routes either the low five bits of the stored word or five external pins onto them. The sixth line always comes from the top bit of the stored word. It passes through a hold stage that is transparent while the stored word is selected. The hold stage freezes the line at the value it showed at the moment select rises to the pin side.

An active-low override clears all six lines, but only while the stored word is selected. When the pins are selected, the five lines follow the pins and the sixth line keeps its held value, whatever the override does. Every input is brought onto the system clock through a two-flop synchroniser. Each output is a drive-low enable: 1 pulls the line low, 0 releases it.

Top module: `cfg_out_select`

## Requirements
- R1: With select 0 and override_n 1, mux line k shows stored bit k (k = 0..4, bit 0 is line A), so `mux_pull_lo[k]` equals the inverse of `cfg_word[k]`.
- R2: With select 1, mux line k shows `ext_in[k]` whatever the level of override_n.
- R3: With select 0 and override_n 1, the held line follows stored bit 5.
- R4: When the synchronised select rises, the held line keeps the value it showed in the cycle before the rise, even if bit 5 changes in the same input cycle. It keeps that value while select stays 1, and later changes of bit 5 have no effect on it.
- R5: With select 0 and override_n 0, all six lines are driven low (all six pull-low enables are 1).
- R6: With select 1, driving override_n to 0 leaves the held line unchanged.
- R7: Every output is a drive-low enable: 1 means the line is pulled low and 0 means it is released.
- R8: An input change reaches the outputs after exactly two rising clock edges: it is absent after the first edge and present after the second.
- R9: During and directly after reset, select, override_n and the external inputs read as 1 (their undriven level), the stored word reads as 0 and the held value is 0. This gives `mux_pull_lo` = 0 and `held_pull_lo` = 1 regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 6 | Stored configuration word; bits 0..4 feed the mux lines, bit 5 feeds the held line |
| ext_in | input | 5 | External pin values for the mux lines |
| sel_in | input | 1 | 0 selects the stored word, 1 selects the pins and freezes the held line |
| ovr_n_in | input | 1 | Active-low override, effective only while select is 0 |
| mux_pull_lo | output | 5 | Drive-low enables of the five mux lines |
| held_pull_lo | output | 1 | Drive-low enable of the held line |

## Verification
If the hold register captures in the wrong cycle, the held line shows a wrong value in the first cycle after the synchronised select rises. The error lasts until select returns to 0. A stale or swapped source in the mux shows on `mux_pull_lo` two edges after the offending input change. An override leak into the pin-select state shows at once on the held line. Changing bit 5 together with the select rise separates a capture taken before the edge from one taken after it.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
  localparam int DEF_MUX_W  = 5;
  localparam int DEF_STAGES = 2;

  typedef enum logic {SRC_REG = 1'b0, SRC_PIN = 1'b1} src_e;

  // value the held line shows while transparent
  function automatic logic shown_value(input logic ovr_n, input logic cfg_top);
    return ovr_n & cfg_top;
  endfunction
endpackage

// File: rtl/cfgsel_sync.sv
module cfgsel_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgsel_hold.sv
module cfgsel_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic shown,
  output logic held_q,
  output logic sel_rise
);
  logic sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d  <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sel_d <= sel_s;
      if (!sel_s) held_q <= shown;
    end
  end

  assign sel_rise = sel_s & ~sel_d;
endmodule

// File: rtl/cfgsel_drive.sv
module cfgsel_drive
  import cfgsel_pkg::*;
#(
  parameter int MUX_W = DEF_MUX_W
) (
  input  logic             sel_s,
  input  logic             ovr_s,
  input  logic [MUX_W:0]   cfg_s,
  input  logic [MUX_W-1:0] ext_s,
  input  logic             held_q,
  output logic             shown,
  output logic [MUX_W-1:0] mux_pull_lo,
  output logic             held_pull_lo
);
  src_e src;
  logic [MUX_W-1:0] mux_val;
  logic held_val;

  assign src   = src_e'(sel_s);
  assign shown = shown_value(ovr_s, cfg_s[MUX_W]);

  for (genvar k = 0; k < MUX_W; k++) begin : g_line
    always_comb begin
      unique case (src)
        SRC_PIN: mux_val[k] = ext_s[k];
        default: mux_val[k] = ovr_s & cfg_s[k];
      endcase
    end
  end

  assign held_val     = (src == SRC_PIN) ? held_q : shown;
  assign mux_pull_lo  = ~mux_val;
  assign held_pull_lo = ~held_val;
endmodule

// File: rtl/cfg_out_select.sv
module cfg_out_select
  import cfgsel_pkg::*;
#(
  parameter int MUX_W  = DEF_MUX_W,
  parameter int STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MUX_W:0]   cfg_word,
  input  logic [MUX_W-1:0] ext_in,
  input  logic             sel_in,
  input  logic             ovr_n_in,
  output logic [MUX_W-1:0] mux_pull_lo,
  output logic             held_pull_lo
);
  localparam int CTL_W = MUX_W + 2;

  logic [CTL_W-1:0] ctl_s;
  logic [MUX_W:0]   cfg_s;
  logic [MUX_W-1:0] ext_s;
  logic sel_s, ovr_s, shown, held_q, sel_rise;

  // undriven-high inputs share one synchroniser bank reset to all ones
  cfgsel_sync #(.W(CTL_W), .STAGES(STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_in, ovr_n_in, ext_in}), .q(ctl_s));

  cfgsel_sync #(.W(MUX_W+1), .STAGES(STAGES), .RST_VAL('0)) u_cfg_sync (
    .clk(clk), .rst_n(rst_n), .d(cfg_word), .q(cfg_s));

  assign sel_s = ctl_s[CTL_W-1];
  assign ovr_s = ctl_s[CTL_W-2];
  assign ext_s = ctl_s[MUX_W-1:0];

  cfgsel_hold u_hold (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .shown(shown),
    .held_q(held_q), .sel_rise(sel_rise));

  cfgsel_drive #(.MUX_W(MUX_W)) u_drive (
    .sel_s(sel_s), .ovr_s(ovr_s), .cfg_s(cfg_s), .ext_s(ext_s), .held_q(held_q),
    .shown(shown), .mux_pull_lo(mux_pull_lo), .held_pull_lo(held_pull_lo));
endmodule

// File: rtl/cfgsel_chk.sv
module cfgsel_chk #(
  parameter int MUX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_s,
  input logic             ovr_s,
  input logic [MUX_W:0]   cfg_s,
  input logic [MUX_W-1:0] ext_s,
  input logic             sel_rise,
  input logic [MUX_W-1:0] mux_pull_lo,
  input logic             held_pull_lo
);
  AST_REG_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && ovr_s) |-> (mux_pull_lo == ~cfg_s[MUX_W-1:0])); // R1
  AST_PIN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |-> (mux_pull_lo == ~ext_s)); // R2
  AST_HELD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && ovr_s) |-> (held_pull_lo == ~cfg_s[MUX_W])); // R3
  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |-> (held_pull_lo == $past(held_pull_lo))); // R4
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !sel_rise) |-> $stable(held_pull_lo)); // R6
  AST_OVERRIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && !ovr_s) |-> (&mux_pull_lo && held_pull_lo)); // R5
endmodule

bind cfg_out_select cfgsel_chk #(.MUX_W(MUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ovr_s(ovr_s), .cfg_s(cfg_s),
  .ext_s(ext_s), .sel_rise(sel_rise), .mux_pull_lo(mux_pull_lo),
  .held_pull_lo(held_pull_lo));

// File: tb/test_cfg_out_select.sv
module test_cfg_out_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfg_word = '0;
  logic [4:0] ext_in = '0;
  logic sel_in = 1'b0;
  logic ovr_n_in = 1'b0;
  logic [4:0] mux_pull_lo;
  logic held_pull_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic held_model = 1'b0;

  always #4 clk = ~clk;

  cfg_out_select i_cfg_out_select (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ext_in(ext_in),
    .sel_in(sel_in), .ovr_n_in(ovr_n_in),
    .mux_pull_lo(mux_pull_lo), .held_pull_lo(held_pull_lo));

  // {sel, ovr_n, ext[4:0], cfg[5:0]}
  localparam logic [12:0] VEC [14] = '{
    {1'b0, 1'b1, 5'b00000, 6'b101101},
    {1'b0, 1'b1, 5'b11111, 6'b010010},
    {1'b0, 1'b0, 5'b10101, 6'b111111},
    {1'b0, 1'b1, 5'b00000, 6'b111111},
    {1'b1, 1'b1, 5'b10110, 6'b011111},
    {1'b1, 1'b1, 5'b01001, 6'b000000},
    {1'b1, 1'b0, 5'b11100, 6'b100000},
    {1'b0, 1'b1, 5'b11100, 6'b000011},
    {1'b1, 1'b1, 5'b00111, 6'b100011},
    {1'b1, 1'b0, 5'b00000, 6'b111111},
    {1'b0, 1'b0, 5'b11111, 6'b100000},
    {1'b1, 1'b1, 5'b10001, 6'b100000},
    {1'b0, 1'b1, 5'b01010, 6'b100001},
    {1'b1, 1'b0, 5'b01010, 6'b000000}
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset state regardless of inputs
    repeat (3) @(negedge clk);
    check("R9 reset", {held_pull_lo, mux_pull_lo}, 6'b100000);
    cfg_word = 6'b111111; ext_in = '0; sel_in = 0; ovr_n_in = 0;
    repeat (2) @(negedge clk);
    check("R9 in reset", {held_pull_lo, mux_pull_lo}, 6'b100000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 after release", {held_pull_lo, mux_pull_lo}, 6'b100000);
    settle();

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 14; i++) begin
      logic s, o;
      logic [4:0] e, em;
      logic [5:0] c;
      {s, o, e, c} = VEC[i];
      sel_in = s; ovr_n_in = o; ext_in = e; cfg_word = c;
      settle();
      em = s ? e : (o ? c[4:0] : 5'b0);
      if (!s) held_model = o & c[5];
      // outputs are drive-low enables (R7)
      check(s ? "R2/R4/R6 vec" : "R1/R3/R5 vec",
            {held_pull_lo, mux_pull_lo}, ~{held_model, em});
    end

    // R4: bit 5 changes in the same cycle select rises
    sel_in = 0; ovr_n_in = 1; cfg_word = 6'b100000; ext_in = 5'b00000;
    settle();
    check("R3 pre", {held_pull_lo, mux_pull_lo}, 6'b011111);
    sel_in = 1; cfg_word = 6'b000000;
    settle();
    check("R4 same-cycle", {held_pull_lo, mux_pull_lo}, 6'b011111);
    cfg_word = 6'b111111;
    settle();
    check("R4 ignore later cfg", {5'b0, held_pull_lo}, 6'b000000);
    ovr_n_in = 0;
    settle();
    check("R6 override in pin mode", {held_pull_lo, mux_pull_lo}, 6'b011111);

    // R8: two-edge latency
    sel_in = 0; ovr_n_in = 1; cfg_word = 6'b000000;
    settle();
    check("R8 base", {held_pull_lo, mux_pull_lo}, 6'b111111);
    cfg_word = 6'b100101;
    @(posedge clk); @(negedge clk);
    check("R8 after one edge", {held_pull_lo, mux_pull_lo}, 6'b111111);
    @(posedge clk); @(negedge clk);
    check("R8 after two edges", {held_pull_lo, mux_pull_lo}, 6'b011010);

    // R5: override while register selected clears all six
    ovr_n_in = 0;
    settle();
    check("R5 override", {held_pull_lo, mux_pull_lo}, 6'b111111);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule